// File: doc/BRIEF.md
# Microcoded Instruction Fetch Loop

This block is the control store, sequencer and register datapath that run the instruction fetch loop of a 12-bit accumulator machine. A case-coded microprogram store sits behind an 8-bit microprogram counter. Each microword carries four things: a branch condition with a target, a register-file read and write, an ALU operation fed by an external data source, and a one-hot control action. The control actions load the memory address register, load the instruction register, or write memory.

The fetch loop takes a fixed number of microwords. The first copies the program counter into the memory address register and a saved-PC slot, and it branches to a halt step when the run input is low. The next step adds a constant from a small constant table to the program counter. The third takes the memory read data into the instruction register and into a memory-buffer slot, then jumps without condition to the execute entry. Execute is a stub that returns to the end step. The end step clears the memory address register. If an interrupt is pending it goes on to the interrupt entry, which is also a stub; if none is pending it goes back to the start.

The memory outside the block is static and asynchronous-read. Its read data follows the address register, and that data is used two microcycles after the address is loaded.

Top module: `fetch_ucode_core`

## Requirements
- R1: A synchronous active-high reset sets the microprogram counter to 0. It clears the program counter, saved PC, memory-buffer copy, instruction register and memory address register to 0.
- R2: In the microword at address 0, the program counter value (register 1) is written into both the memory address register and the saved-PC slot (register 2). The program counter keeps its value.
- R3: At address 0, a low run input makes the next microprogram address octal 010. A high run input makes it 1.
- R4: At octal 010, the microprogram counter holds while run is low and halted_o is 1. When run is high the next address is 0. halted_o is 1 exactly when the microprogram counter is octal 010.
- R5: At address 1, the program counter becomes its old value plus constant-table entry 1, which holds 1. The sum wraps from 4095 to 0. The next address is 2.
- R6: At address 2, the instruction register and the memory-buffer copy (register 5) both take the memory read data present in that cycle. That data is the word at the address loaded two cycles earlier.
- R7: Address 2 always jumps to octal 040. Octal 040 always jumps to address 4.
- R8: At address 4 the memory address register becomes 0. The next address is 0 when irq_i is low and 5 when it is high. Address 5 always jumps to address 4.
- R9: The fetch microcode never asserts mem_we_o.
- R10: pc_o, lastpc_o, mb_o, ir_o and mem_addr_o show the current register contents, and upc_o shows the current microprogram address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Microcycle clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Run enable tested at the fetch and halt steps |
| irq_i | input | 1 | Pending interrupt tested at the end step |
| mem_rdata_i | input | 12 | Static memory read data for the current address |
| mem_addr_o | output | 12 | Memory address register |
| mem_wdata_o | output | 12 | ALU result offered as memory write data |
| mem_we_o | output | 1 | Memory write enable |
| upc_o | output | 8 | Current microprogram address |
| pc_o | output | 12 | Program counter (register 1) |
| lastpc_o | output | 12 | Saved PC (register 2) |
| mb_o | output | 12 | Memory-buffer copy (register 5) |
| ir_o | output | 12 | Instruction register |
| halted_o | output | 1 | High while parked at the halt step |

## Verification
The assertions check every step transition on every cycle. That covers the run and interrupt branch choices, the copy of PC into the address register and saved PC, the PC increment, the capture of read data into IR and the buffer slot, the clear at the end step, and the absence of writes. The bench scenarios are what show the reset values. They also show that the captured instruction is the memory word at the fetched PC two cycles after the address load. The same scenarios cover the halt park and release, the interrupt detour over more than one pass, and the program counter wrapping after 4096 fetches.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int unsigned DATA_W = 12;
    localparam int unsigned UPC_W  = 8;
    localparam int unsigned RF_N   = 8;
    localparam int unsigned RF_IW  = $clog2(RF_N);
    localparam int unsigned KT_N   = 16;
    localparam int unsigned KT_IW  = $clog2(KT_N);

    // register file slots
    localparam logic [RF_IW-1:0] RF_PC     = RF_IW'(1);
    localparam logic [RF_IW-1:0] RF_LASTPC = RF_IW'(2);
    localparam logic [RF_IW-1:0] RF_MB     = RF_IW'(5);

    // microprogram addresses
    localparam logic [UPC_W-1:0] UA_RUN  = UPC_W'(0);
    localparam logic [UPC_W-1:0] UA_INC  = UPC_W'(1);
    localparam logic [UPC_W-1:0] UA_IR   = UPC_W'(2);
    localparam logic [UPC_W-1:0] UA_END  = UPC_W'(4);
    localparam logic [UPC_W-1:0] UA_IRQ  = UPC_W'(5);
    localparam logic [UPC_W-1:0] UA_HALT = UPC_W'(8);
    localparam logic [UPC_W-1:0] UA_EXEC = UPC_W'(32);

    typedef enum logic [2:0] {
        CC_NEVER,
        CC_ALWAYS,
        CC_RUN_LOW,
        CC_RUN_HIGH,
        CC_NO_IRQ
    } cond_e;

    typedef enum logic {
        ELSE_NEXT,
        ELSE_HOLD
    } else_e;

    typedef enum logic [1:0] {
        OP_ZERO,
        OP_PASS_A,
        OP_PASS_D,
        OP_ADD
    } alu_op_e;

    typedef enum logic [1:0] {
        DSRC_NONE,
        DSRC_MEM,
        DSRC_CONST
    } dsrc_e;

    typedef enum logic [1:0] {
        CTL_NONE,
        CTL_LD_MAR,
        CTL_LD_IR,
        CTL_MEM_WR
    } ctl_e;

    typedef struct packed {
        cond_e              cc;
        else_e              els;
        logic [UPC_W-1:0]   target;
        logic [RF_IW-1:0]   a_sel;
        alu_op_e            op;
        dsrc_e              dsrc;
        logic [KT_IW-1:0]   k_sel;
        logic               rf_we;
        logic [RF_IW-1:0]   rf_dst;
        ctl_e               ctl;
    } uword_t;

    function automatic uword_t mk_uw(
        input cond_e            cc,
        input else_e            els,
        input logic [UPC_W-1:0] target,
        input logic [RF_IW-1:0] a_sel,
        input alu_op_e          op,
        input dsrc_e            dsrc,
        input logic [KT_IW-1:0] k_sel,
        input logic             rf_we,
        input logic [RF_IW-1:0] rf_dst,
        input ctl_e             ctl
    );
        uword_t w;
        w.cc     = cc;
        w.els    = els;
        w.target = target;
        w.a_sel  = a_sel;
        w.op     = op;
        w.dsrc   = dsrc;
        w.k_sel  = k_sel;
        w.rf_we  = rf_we;
        w.rf_dst = rf_dst;
        w.ctl    = ctl;
        return w;
    endfunction

    // constant table: entry 0 is zero, entry k is a single bit at k-1
    function automatic logic [DATA_W-1:0] const_word(input logic [KT_IW-1:0] k);
        logic [DATA_W-1:0] v;
        v = '0;
        if (k != '0 && int'(k) <= int'(DATA_W))
            v[int'(k) - 1] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/fetch_ucode_rom.sv
module fetch_ucode_rom
    import fetch_pkg::*;
(
    input  logic [UPC_W-1:0] addr,
    output uword_t           uw
);

    always_comb begin
        case (addr)
            UA_RUN:  uw = mk_uw(CC_RUN_LOW, ELSE_NEXT, UA_HALT, RF_PC, OP_PASS_A,
                                DSRC_NONE, '0, 1'b1, RF_LASTPC, CTL_LD_MAR);
            UA_INC:  uw = mk_uw(CC_NEVER, ELSE_NEXT, '0, RF_PC, OP_ADD,
                                DSRC_CONST, KT_IW'(1), 1'b1, RF_PC, CTL_NONE);
            UA_IR:   uw = mk_uw(CC_ALWAYS, ELSE_NEXT, UA_EXEC, '0, OP_PASS_D,
                                DSRC_MEM, '0, 1'b1, RF_MB, CTL_LD_IR);
            UA_END:  uw = mk_uw(CC_NO_IRQ, ELSE_NEXT, UA_RUN, '0, OP_ZERO,
                                DSRC_NONE, '0, 1'b0, '0, CTL_LD_MAR);
            UA_IRQ:  uw = mk_uw(CC_ALWAYS, ELSE_NEXT, UA_END, '0, OP_ZERO,
                                DSRC_NONE, '0, 1'b0, '0, CTL_NONE);
            UA_HALT: uw = mk_uw(CC_RUN_HIGH, ELSE_HOLD, UA_RUN, '0, OP_ZERO,
                                DSRC_NONE, '0, 1'b0, '0, CTL_NONE);
            UA_EXEC: uw = mk_uw(CC_ALWAYS, ELSE_NEXT, UA_END, '0, OP_ZERO,
                                DSRC_NONE, '0, 1'b0, '0, CTL_NONE);
            default: uw = mk_uw(CC_ALWAYS, ELSE_NEXT, UA_RUN, '0, OP_ZERO,
                                DSRC_NONE, '0, 1'b0, '0, CTL_NONE);
        endcase
    end

endmodule

// File: rtl/fetch_useq.sv
module fetch_useq
    import fetch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cond_e            cc,
    input  else_e            els,
    input  logic [UPC_W-1:0] target,
    input  logic             run,
    input  logic             irq,
    output logic [UPC_W-1:0] upc
);

    logic             taken;
    logic [UPC_W-1:0] upc_nxt;

    always_comb begin
        case (cc)
            CC_ALWAYS:   taken = 1'b1;
            CC_RUN_LOW:  taken = !run;
            CC_RUN_HIGH: taken = run;
            CC_NO_IRQ:   taken = !irq;
            default:     taken = 1'b0;
        endcase
    end

    always_comb begin
        if (taken)
            upc_nxt = target;
        else if (els == ELSE_HOLD)
            upc_nxt = upc;
        else
            upc_nxt = upc + UPC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            upc <= '0;
        else
            upc <= upc_nxt;
    end

endmodule

// File: rtl/fetch_rf.sv
module fetch_rf #(
    parameter int unsigned W     = 12,
    parameter int unsigned N     = 8,
    parameter int unsigned IW    = $clog2(N),
    parameter int unsigned TAP_A = 1,
    parameter int unsigned TAP_B = 2,
    parameter int unsigned TAP_C = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] raddr,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  tap_a,
    output logic [W-1:0]  tap_b,
    output logic [W-1:0]  tap_c
);

    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (we && waddr == IW'(i))
                regs[i] <= wdata;
        end
    end

    assign rdata = regs[raddr];
    assign tap_a = regs[TAP_A];
    assign tap_b = regs[TAP_B];
    assign tap_c = regs[TAP_C];

endmodule

// File: rtl/fetch_alu.sv
module fetch_alu
    import fetch_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] d,
    output logic [W-1:0] y
);

    always_comb begin
        case (op)
            OP_PASS_A: y = a;
            OP_PASS_D: y = d;
            OP_ADD:    y = a + d;
            default:   y = '0;
        endcase
    end

endmodule

// File: rtl/fetch_ucode_core.sv
module fetch_ucode_core
    import fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              irq_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              mem_we_o,
    output logic [UPC_W-1:0]  upc_o,
    output logic [DATA_W-1:0] pc_o,
    output logic [DATA_W-1:0] lastpc_o,
    output logic [DATA_W-1:0] mb_o,
    output logic [DATA_W-1:0] ir_o,
    output logic              halted_o
);

    logic [UPC_W-1:0]  upc;
    uword_t            uw;
    logic [DATA_W-1:0] a_val;
    logic [DATA_W-1:0] d_val;
    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] mar_q;
    logic [DATA_W-1:0] ir_q;

    fetch_ucode_rom u_rom (
        .addr (upc),
        .uw   (uw)
    );

    fetch_useq u_seq (
        .clk    (clk),
        .rst    (rst),
        .cc     (uw.cc),
        .els    (uw.els),
        .target (uw.target),
        .run    (run_i),
        .irq    (irq_i),
        .upc    (upc)
    );

    always_comb begin
        case (uw.dsrc)
            DSRC_MEM:   d_val = mem_rdata_i;
            DSRC_CONST: d_val = const_word(uw.k_sel);
            default:    d_val = '0;
        endcase
    end

    fetch_alu #(.W(DATA_W)) u_alu (
        .op (uw.op),
        .a  (a_val),
        .d  (d_val),
        .y  (alu_y)
    );

    fetch_rf #(
        .W     (DATA_W),
        .N     (RF_N),
        .IW    (RF_IW),
        .TAP_A (int'(RF_PC)),
        .TAP_B (int'(RF_LASTPC)),
        .TAP_C (int'(RF_MB))
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (uw.rf_we),
        .waddr (uw.rf_dst),
        .wdata (alu_y),
        .raddr (uw.a_sel),
        .rdata (a_val),
        .tap_a (pc_o),
        .tap_b (lastpc_o),
        .tap_c (mb_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q <= '0;
            ir_q  <= '0;
        end else begin
            if (uw.ctl == CTL_LD_MAR) mar_q <= alu_y;
            if (uw.ctl == CTL_LD_IR)  ir_q  <= alu_y;
        end
    end

    assign mem_addr_o  = mar_q;
    assign mem_wdata_o = alu_y;
    assign mem_we_o    = (uw.ctl == CTL_MEM_WR);
    assign ir_o        = ir_q;
    assign upc_o       = upc;
    assign halted_o    = (upc == UA_HALT);

endmodule

// File: rtl/fetch_ucode_chk.sv
module fetch_ucode_chk
    import fetch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              run_i,
    input logic              irq_i,
    input logic [DATA_W-1:0] mem_rdata_i,
    input logic [DATA_W-1:0] mem_addr_o,
    input logic              mem_we_o,
    input logic [UPC_W-1:0]  upc_o,
    input logic [DATA_W-1:0] pc_o,
    input logic [DATA_W-1:0] lastpc_o,
    input logic [DATA_W-1:0] mb_o,
    input logic [DATA_W-1:0] ir_o
);

    // R2
    fetch_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_o == UA_RUN) |=> (mem_addr_o == $past(pc_o) && lastpc_o == $past(pc_o)
                               && pc_o == $past(pc_o)));

    // R3
    run_low_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_o == UA_RUN && !run_i) |=> (upc_o == UA_HALT));

    // R3
    run_high_go_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_o == UA_RUN && run_i) |=> (upc_o == UA_INC));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_o == UA_HALT && !run_i) |=> (upc_o == UA_HALT));

    // R4
    halt_release_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_o == UA_HALT && run_i) |=> (upc_o == UA_RUN));

    // R5
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_o == UA_INC) |=> (pc_o == $past(pc_o) + DATA_W'(1) && upc_o == UA_IR));

    // R6
    ir_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_o == UA_IR) |=> (ir_o == $past(mem_rdata_i) && mb_o == $past(mem_rdata_i)));

    // R7
    exec_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_o == UA_IR) |=> (upc_o == UA_EXEC));

    // R7
    exec_return_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_o == UA_EXEC) |=> (upc_o == UA_END));

    // R8
    end_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_o == UA_END) |=> (mem_addr_o == '0));

    // R8
    end_branch_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_o == UA_END) |=> (upc_o == ($past(irq_i) ? UA_IRQ : UA_RUN)));

    // R8
    irq_return_chk: assert property (@(posedge clk) disable iff (rst)
        (upc_o == UA_IRQ) |=> (upc_o == UA_END));

    // R9
    no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_o);

endmodule

bind fetch_ucode_core fetch_ucode_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run_i),
    .irq_i       (irq_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .upc_o       (upc_o),
    .pc_o        (pc_o),
    .lastpc_o    (lastpc_o),
    .mb_o        (mb_o),
    .ir_o        (ir_o)
);

// File: tb/fetch_ucode_core_bench.sv
`timescale 1ns/1ps
module fetch_ucode_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        irq = 1'b0;
    logic [11:0] rdata;
    logic [11:0] addr;
    logic [11:0] wdata;
    logic        we;
    logic [7:0]  upc;
    logic [11:0] pc, lastpc, mb, ir;
    logic        halted;

    int checks = 0;
    int fails  = 0;

    logic [11:0] mem [4096];

    always #2 clk = ~clk;

    fetch_ucode_core u_fetch_ucode_core (
        .clk         (clk),
        .rst         (rst),
        .run_i       (run),
        .irq_i       (irq),
        .mem_rdata_i (rdata),
        .mem_addr_o  (addr),
        .mem_wdata_o (wdata),
        .mem_we_o    (we),
        .upc_o       (upc),
        .pc_o        (pc),
        .lastpc_o    (lastpc),
        .mb_o        (mb),
        .ir_o        (ir),
        .halted_o    (halted)
    );

    function automatic logic [11:0] pattern(input int a);
        return 12'((a * 37 + 5) & 12'hfff);
    endfunction

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = pattern(i);
    end

    assign rdata = mem[addr];

    always @(posedge clk) if (we) mem[addr] <= wdata;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_upc, m_pc, m_last, m_mb, m_ir, m_mar;
    bit started = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_upc = 0; m_pc = 0; m_last = 0; m_mb = 0; m_ir = 0; m_mar = 0;
            started = 1;
        end else begin
            case (m_upc)
                0:  begin
                        m_mar  = m_pc;
                        m_last = m_pc;
                        m_upc  = run ? 1 : 8;
                    end
                1:  begin m_pc = (m_pc + 1) % 4096; m_upc = 2; end
                2:  begin
                        m_ir  = int'(pattern(m_mar));
                        m_mb  = m_ir;
                        m_upc = 32;
                    end
                32: m_upc = 4;
                4:  begin m_mar = 0; m_upc = irq ? 5 : 0; end
                5:  m_upc = 4;
                8:  m_upc = run ? 0 : 8;
                default: m_upc = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (started) begin
            chk("R10 upc_o", int'(upc), m_upc);
            chk("R5 pc_o", int'(pc), m_pc);
            chk("R2 lastpc_o", int'(lastpc), m_last);
            chk("R2 mem_addr_o", int'(addr), m_mar);
            chk("R6 ir_o", int'(ir), m_ir);
            chk("R6 mb_o", int'(mb), m_mb);
            chk("R9 mem_we_o", int'(we), 0);
            chk("R4 halted_o", int'(halted), (m_upc == 8) ? 1 : 0);
        end
    end

    task automatic wait_upc(input int target);
        do @(negedge clk); while (int'(upc) != target);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int exp_ir;
        int pc_at;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset upc", int'(upc), 0);
        chk("R1 reset pc", int'(pc), 0);
        chk("R1 reset ir", int'(ir), 0);
        chk("R1 reset mar", int'(addr), 0);
        rst = 1'b0;
        run = 1'b1;

        // R3 / R2: fetch step with run high
        @(negedge clk);
        chk("R3 run high next", int'(upc), 1);
        chk("R2 mar from pc", int'(addr), 0);
        @(negedge clk);
        chk("R5 pc increment", int'(pc), 1);
        exp_ir = int'(pattern(0));
        @(negedge clk);
        chk("R6 ir capture", int'(ir), exp_ir);
        chk("R6 mb capture", int'(mb), exp_ir);
        chk("R7 exec entry", int'(upc), 32);
        @(negedge clk);
        chk("R7 exec return", int'(upc), 4);
        @(negedge clk);
        chk("R8 mar cleared", int'(addr), 0);
        chk("R8 no irq to start", int'(upc), 0);

        // several more fetches
        for (int k = 0; k < 6; k++) begin
            wait_upc(2);
            pc_at = int'(addr);
            @(negedge clk);
            chk("R6 fetched word", int'(ir), int'(pattern(pc_at)));
        end

        // R8 interrupt detour
        irq = 1'b1;
        wait_upc(4);
        @(negedge clk);
        chk("R8 irq entry", int'(upc), 5);
        chk("R8 mar cleared irq", int'(addr), 0);
        @(negedge clk);
        chk("R8 irq return", int'(upc), 4);
        irq = 1'b0;
        @(negedge clk);
        chk("R8 back to start", int'(upc), 0);

        // R3 / R4 halt park and release
        run = 1'b0;
        pc_at = int'(pc);
        @(negedge clk);
        chk("R3 run low to halt", int'(upc), 8);
        chk("R4 halted flag", int'(halted), 1);
        chk("R2 mar on halt path", int'(addr), pc_at);
        repeat (5) @(negedge clk);
        chk("R4 halt holds", int'(upc), 8);
        chk("R4 pc held in halt", int'(pc), pc_at);
        run = 1'b1;
        @(negedge clk);
        chk("R4 halt release", int'(upc), 0);
        chk("R4 halted cleared", int'(halted), 0);

        // R5 wrap of program counter
        do @(negedge clk); while (!(int'(upc) == 1 && int'(pc) == 4095));
        @(negedge clk);
        chk("R5 pc wrap", int'(pc), 0);
        @(negedge clk);
        chk("R6 ir at last word", int'(ir), int'(pattern(4095)));

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule